// File: doc/BRIEF.md
# Five-State Snooping Line Controller

This block keeps coherence for a small direct-mapped write-back cache that sits on a snooping bus shared with peer caches and a memory controller. Each line holds one data word, a tag and one of five coherence states: modified, owned, exclusive, shared and invalid. The owned state lets a dirty block stay shared without updating memory. Exactly one cache, the last writer, owns the block and supplies it to readers. Memory is updated only when a dirty line leaves a cache.

The processor side takes one request at a time: read, write or explicit eviction. A request that can finish locally completes without bus traffic. Otherwise the controller posts a bus command and holds it until the arbiter grants it. For a read or read-exclusive, it then waits for the fill word. The snoop side watches every bus command issued by other caches. It updates the matching line and, when it must supply data, answers one cycle later. The answer is marked either as a dirty flush, which comes from an owner or a modified holder, or as an optional clean flush.

Memory absorbs only write-back commands. It ignores both kinds of snoop flush.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is high, and no bus request, processor response or snoop response is active. A snooped read then gets no response and `snp_copy` stays low.
- R2: A read that misses posts bus command 0 (read). The fill leaves the line exclusive when `bus_fill_shared` is low and shared when it is high, and returns the fill word. A read that hits posts nothing and returns the stored word.
- R3: A write to a modified or exclusive line completes with no bus command. A write to an owned or shared line posts command 2 (upgrade). A write that misses posts command 1 (read-exclusive). In every case the line ends modified and holds the write data.
- R4: Evicting a modified or owned line posts command 3 (write-back), carrying that line's address and word, and leaves the line invalid. Evicting an exclusive, shared or absent line posts nothing.
- R5: A read or write miss onto a slot whose current line is modified or owned first posts a write-back of that victim and then the fill command. A clean victim is dropped without any write-back.
- R6: A snooped read (command 0) that hits a modified line answers with a dirty flush (`snp_resp_dirty` = 1) of the word and moves the line to owned. On an owned line it answers the same way and the line stays owned.
- R7: A snooped read that hits an exclusive line answers with a clean flush (`snp_resp_dirty` = 0) and moves the line to shared. On a shared line it gives no answer. Any hit by a snooped read raises `snp_copy`.
- R8: A snooped read-exclusive (command 1) that hits a modified or owned line answers with a dirty flush. On an exclusive line it answers with a clean flush, and on a shared line it gives no answer. In all of these cases the line becomes invalid.
- R9: A snooped upgrade (command 2) that hits moves the line to invalid with no answer.
- R10: A snoop whose address misses the line, or whose command is 3, gives no answer and leaves the line unchanged.
- R11: A snoop answer appears exactly one cycle after the snoop. A posted bus command stays unchanged until granted while no snoop intervenes. The processor response is a one-cycle pulse, and `cpu_req_ready` is high while the response is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_valid | input | 1 | Processor request present (taken when ready) |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 or 3 evict |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_ready | output | 1 | Controller idle and able to take a request |
| cpu_resp_valid | output | 1 | Request finished (one-cycle pulse) |
| cpu_resp_rdata | output | DATA_W | Read result |
| bus_req_valid | output | 1 | Bus command posted |
| bus_req_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_req_addr | output | ADDR_W | Address of the posted command |
| bus_req_data | output | DATA_W | Word written back (command 3) |
| bus_gnt | input | 1 | Arbiter grants the posted command this cycle |
| bus_fill_valid | input | 1 | Fill word for the granted read or read-exclusive |
| bus_fill_data | input | DATA_W | Fill word |
| bus_fill_shared | input | 1 | Copies-exist line sampled with the fill |
| snp_valid | input | 1 | Command from another cache seen on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_req_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_resp_valid | output | 1 | This cache supplies the block |
| snp_resp_dirty | output | 1 | 1 dirty flush, 0 optional clean flush |
| snp_resp_data | output | DATA_W | Supplied word |
| snp_copy | output | 1 | This cache holds the block read by the snoop |

## Verification
The assertions rely on a few properties of the bus. The arbiter raises `bus_gnt` only while a command is posted, and never in a cycle that carries a snoop. A fill arrives only after a granted read or read-exclusive and never together with a snoop. The bus serializes transactions, so the controller's own command is never fed back as a snoop. The bench keeps within these limits because one task drives the processor request, its grants and its fills, and a separate task runs snoops only while the controller is idle.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    LN_I = 3'd0,
    LN_S = 3'd1,
    LN_E = 3'd2,
    LN_O = 3'd3,
    LN_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD   = 2'd0,
    BC_RDX  = 2'd1,
    BC_UPGR = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_EV  = 2'd2,
    OP_EV2 = 2'd3
  } cpu_op_e;

  function automatic logic is_dirty(line_st_e s);
    return (s == LN_M) || (s == LN_O);
  endfunction

endpackage

// File: rtl/moesi_store.sv
module moesi_store
  import moesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              snp_we,
  input  line_st_e          snp_state,
  input  logic              cpu_st_we,
  input  line_st_e          cpu_state,
  input  logic              cpu_tag_we,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic              cpu_dat_we,
  input  logic [DATA_W-1:0] cpu_data
);

  line_st_e          st_arr  [LINES];
  logic [TAG_W-1:0]  tag_arr [LINES];
  logic [DATA_W-1:0] dat_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;

    // snoop updates win over processor updates to the same slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                st_q <= LN_I;
      else if (snp_we && b_idx == IDX_W'(g))     st_q <= snp_state;
      else if (cpu_st_we && a_idx == IDX_W'(g))  st_q <= cpu_state;
    end

    always_ff @(posedge clk) begin
      if (cpu_tag_we && a_idx == IDX_W'(g)) tag_q <= cpu_tag;
    end

    always_ff @(posedge clk) begin
      if (cpu_dat_we && a_idx == IDX_W'(g)) dat_q <= cpu_data;
    end

    assign st_arr[g]  = st_q;
    assign tag_arr[g] = tag_q;
    assign dat_arr[g] = dat_q;
  end

  assign a_state = st_arr[a_idx];
  assign a_tag   = tag_arr[a_idx];
  assign a_data  = dat_arr[a_idx];
  assign b_state = st_arr[b_idx];
  assign b_tag   = tag_arr[b_idx];
  assign b_data  = dat_arr[b_idx];

endmodule

// File: rtl/moesi_snoop.sv
module moesi_snoop
  import moesi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_e          line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              upd_we,
  output line_st_e          upd_state,
  output logic              resp_valid,
  output logic              resp_dirty,
  output logic [DATA_W-1:0] resp_data,
  output logic              copy
);

  logic hit, rv_d, rd_d, cp_d;
  logic rv_q, rd_q, cp_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    hit       = snp_valid && (line_state != LN_I) && (line_tag == snp_tag);
    upd_state = line_state;
    rv_d      = 1'b0;
    rd_d      = 1'b0;
    cp_d      = 1'b0;
    if (hit) begin
      unique case (snp_cmd)
        BC_RD: begin
          cp_d = 1'b1;
          if (is_dirty(line_state)) begin
            rv_d      = 1'b1;
            rd_d      = 1'b1;
            upd_state = LN_O;
          end else if (line_state == LN_E) begin
            rv_d      = 1'b1;
            upd_state = LN_S;
          end
        end
        BC_RDX: begin
          rv_d      = (line_state != LN_S);
          rd_d      = is_dirty(line_state);
          upd_state = LN_I;
        end
        BC_UPGR: upd_state = LN_I;
        default: upd_state = line_state;
      endcase
    end
    upd_we = hit && (upd_state != line_state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= 1'b0;
      cp_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      rd_q <= rd_d;
      cp_q <= cp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rv_d) data_q <= line_data;
  end

  assign resp_valid = rv_q;
  assign resp_dirty = rd_q;
  assign resp_data  = data_q;
  assign copy       = cp_q;

endmodule

// File: rtl/moesi_cpu_fsm.sv
module moesi_cpu_fsm
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  cpu_op_e           req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [IDX_W-1:0]  line_idx,
  input  line_st_e          line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              hold,
  output logic              st_we,
  output line_st_e          st_val,
  output logic              tag_we,
  output logic [TAG_W-1:0]  tag_val,
  output logic              dat_we,
  output logic [DATA_W-1:0] dat_val,
  output logic              bus_valid,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  input  logic              bus_gnt,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_shared
);

  typedef enum logic [1:0] {F_IDLE, F_ACT, F_FILL} fsm_e;

  fsm_e              fsm_q, fsm_d;
  cpu_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done, resp_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              hit, dirty;
  logic [TAG_W-1:0]  tag_q;

  assign line_idx = addr_q[IDX_W-1:0];
  assign tag_q    = addr_q[ADDR_W-1:IDX_W];
  assign tag_val  = tag_q;
  assign bus_data = line_data;
  assign hit      = (line_state != LN_I) && (line_tag == tag_q);
  assign dirty    = is_dirty(line_state);

  always_comb begin
    fsm_d     = fsm_q;
    st_we     = 1'b0;
    st_val    = line_state;
    tag_we    = 1'b0;
    dat_we    = 1'b0;
    dat_val   = wdata_q;
    bus_valid = 1'b0;
    bus_cmd   = BC_RD;
    bus_addr  = addr_q;
    done      = 1'b0;
    rdata_d   = line_data;
    unique case (fsm_q)
      F_IDLE: if (req_valid) fsm_d = F_ACT;
      F_ACT: begin
        if (!hit && dirty && op_q != OP_EV && op_q != OP_EV2) begin
          // victim write-back ahead of the fill
          bus_valid = 1'b1;
          bus_cmd   = BC_WB;
          bus_addr  = {line_tag, line_idx};
          if (bus_gnt) begin
            st_we  = 1'b1;
            st_val = LN_I;
          end
        end else begin
          unique case (op_q)
            OP_RD: begin
              if (hit) begin
                if (!hold) begin
                  done  = 1'b1;
                  fsm_d = F_IDLE;
                end
              end else begin
                bus_valid = 1'b1;
                bus_cmd   = BC_RD;
                if (bus_gnt) fsm_d = F_FILL;
              end
            end
            OP_WR: begin
              if (hit && (line_state == LN_M || line_state == LN_E)) begin
                if (!hold) begin
                  st_we  = 1'b1;
                  st_val = LN_M;
                  dat_we = 1'b1;
                  done   = 1'b1;
                  fsm_d  = F_IDLE;
                end
              end else if (hit) begin
                bus_valid = 1'b1;
                bus_cmd   = BC_UPGR;
                if (bus_gnt) begin
                  st_we  = 1'b1;
                  st_val = LN_M;
                  dat_we = 1'b1;
                  done   = 1'b1;
                  fsm_d  = F_IDLE;
                end
              end else begin
                bus_valid = 1'b1;
                bus_cmd   = BC_RDX;
                if (bus_gnt) fsm_d = F_FILL;
              end
            end
            default: begin
              if (hit && dirty) begin
                bus_valid = 1'b1;
                bus_cmd   = BC_WB;
                if (bus_gnt) begin
                  st_we  = 1'b1;
                  st_val = LN_I;
                  done   = 1'b1;
                  fsm_d  = F_IDLE;
                end
              end else if (!hold) begin
                st_we  = hit;
                st_val = LN_I;
                done   = 1'b1;
                fsm_d  = F_IDLE;
              end
            end
          endcase
        end
      end
      default: begin
        if (fill_valid) begin
          st_we   = 1'b1;
          tag_we  = 1'b1;
          dat_we  = 1'b1;
          rdata_d = fill_data;
          if (op_q == OP_WR) begin
            st_val = LN_M;
          end else begin
            st_val  = fill_shared ? LN_S : LN_E;
            dat_val = fill_data;
          end
          done  = 1'b1;
          fsm_d = F_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= F_IDLE;
      resp_q <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      resp_q <= done;
    end
  end

  always_ff @(posedge clk) begin
    if (req_ready && req_valid) begin
      op_q    <= req_op;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
    if (done) rdata_q <= rdata_d;
  end

  assign req_ready  = (fsm_q == F_IDLE);
  assign resp_valid = resp_q;
  assign resp_rdata = rdata_q;

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic [1:0]        cpu_req_op,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_gnt,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              bus_fill_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_resp_valid,
  output logic              snp_resp_dirty,
  output logic [DATA_W-1:0] snp_resp_data,
  output logic              snp_copy
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [IDX_W-1:0]  a_idx;
  line_st_e          a_state, b_state, cpu_state, snp_state;
  logic [TAG_W-1:0]  a_tag, b_tag, cpu_tag;
  logic [DATA_W-1:0] a_data, b_data, cpu_data;
  logic              cpu_st_we, cpu_tag_we, cpu_dat_we, snp_we;
  bus_cmd_e          cmd_int;

  moesi_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .a_idx      (a_idx),
    .a_state    (a_state),
    .a_tag      (a_tag),
    .a_data     (a_data),
    .b_idx      (snp_addr[IDX_W-1:0]),
    .b_state    (b_state),
    .b_tag      (b_tag),
    .b_data     (b_data),
    .snp_we     (snp_we),
    .snp_state  (snp_state),
    .cpu_st_we  (cpu_st_we),
    .cpu_state  (cpu_state),
    .cpu_tag_we (cpu_tag_we),
    .cpu_tag    (cpu_tag),
    .cpu_dat_we (cpu_dat_we),
    .cpu_data   (cpu_data)
  );

  moesi_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .snp_valid  (snp_valid),
    .snp_cmd    (bus_cmd_e'(snp_cmd)),
    .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
    .line_state (b_state),
    .line_tag   (b_tag),
    .line_data  (b_data),
    .upd_we     (snp_we),
    .upd_state  (snp_state),
    .resp_valid (snp_resp_valid),
    .resp_dirty (snp_resp_dirty),
    .resp_data  (snp_resp_data),
    .copy       (snp_copy)
  );

  moesi_cpu_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .req_valid   (cpu_req_valid),
    .req_op      (cpu_op_e'(cpu_req_op)),
    .req_addr    (cpu_req_addr),
    .req_wdata   (cpu_req_wdata),
    .req_ready   (cpu_req_ready),
    .resp_valid  (cpu_resp_valid),
    .resp_rdata  (cpu_resp_rdata),
    .line_idx    (a_idx),
    .line_state  (a_state),
    .line_tag    (a_tag),
    .line_data   (a_data),
    .hold        (snp_valid),
    .st_we       (cpu_st_we),
    .st_val      (cpu_state),
    .tag_we      (cpu_tag_we),
    .tag_val     (cpu_tag),
    .dat_we      (cpu_dat_we),
    .dat_val     (cpu_data),
    .bus_valid   (bus_req_valid),
    .bus_cmd     (cmd_int),
    .bus_addr    (bus_req_addr),
    .bus_data    (bus_req_data),
    .bus_gnt     (bus_gnt),
    .fill_valid  (bus_fill_valid),
    .fill_data   (bus_fill_data),
    .fill_shared (bus_fill_shared)
  );

  assign bus_req_cmd = cmd_int;

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_ready,
  input logic              cpu_resp_valid,
  input logic              bus_req_valid,
  input logic [1:0]        bus_req_cmd,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_resp_valid,
  input logic              snp_copy
);

  AST_SNP_RESP_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_resp_valid |-> $past(snp_valid)); // R11

  AST_UPGR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd == 2'd2 |=> !snp_resp_valid); // R9

  AST_WB_SNOOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd == 2'd3 |=> !snp_resp_valid && !snp_copy); // R10

  AST_COPY_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    snp_copy |-> $past(snp_valid && snp_cmd == 2'd0)); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_gnt && !snp_valid |=>
      bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr)); // R11

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_req_ready); // R11

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |-> cpu_req_ready); // R11

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/moesi_line_ctrl_bench.sv
module moesi_line_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req_valid, cpu_req_ready, cpu_resp_valid;
  logic [1:0]    cpu_req_op;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata, cpu_resp_rdata;
  logic          bus_req_valid, bus_gnt, bus_fill_valid, bus_fill_shared;
  logic [1:0]    bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic [DW-1:0] bus_req_data, bus_fill_data;
  logic          snp_valid, snp_resp_valid, snp_resp_dirty, snp_copy;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic [DW-1:0] snp_resp_data;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit mon_on = 1'b0;
  logic snp_seen = 1'b0;

  // model: 0 I, 1 S, 2 E, 3 O, 4 M
  int ms [4];
  int mt [4];
  int md [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  moesi_line_ctrl u_moesi_line_ctrl (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    snp_seen <= snp_valid;
    if (cyc > 100000) begin
      chk(1'b0, "R11", "watchdog expired", cyc, 100000);
      finish_run();
    end
  end

  // every-clock comparison: a snoop answer only follows a snoop
  always @(negedge clk) begin
    if (mon_on) chk(!snp_resp_valid || snp_seen, "R11", "unsolicited snoop answer",
                    snp_resp_valid, 0);
  end

  task automatic do_cpu(input int op, input int addr, input int wd, input int fd,
                        input bit fsh, input string req);
    int q_cmd[$];
    int q_adr[$];
    int q_dat[$];
    int idx, tg, exp_rd, c;
    bit hit, dirty, got;
    idx   = addr & 3;
    tg    = addr >> 2;
    hit   = (ms[idx] != 0) && (mt[idx] == tg);
    dirty = (ms[idx] == 3) || (ms[idx] == 4);
    exp_rd = md[idx];
    if (op != 2 && !hit && dirty) begin
      q_cmd.push_back(3); q_adr.push_back((mt[idx] << 2) | idx); q_dat.push_back(md[idx]);
      ms[idx] = 0;
    end
    if (op == 0) begin
      if (!hit) begin
        q_cmd.push_back(0); q_adr.push_back(addr); q_dat.push_back(0);
        ms[idx] = fsh ? 1 : 2; mt[idx] = tg; md[idx] = fd; exp_rd = fd;
      end
    end else if (op == 1) begin
      if (hit && (ms[idx] == 4 || ms[idx] == 2)) begin
        ms[idx] = 4; md[idx] = wd;
      end else if (hit) begin
        q_cmd.push_back(2); q_adr.push_back(addr); q_dat.push_back(0);
        ms[idx] = 4; md[idx] = wd;
      end else begin
        q_cmd.push_back(1); q_adr.push_back(addr); q_dat.push_back(0);
        ms[idx] = 4; mt[idx] = tg; md[idx] = wd;
      end
    end else begin
      if (hit && dirty) begin
        q_cmd.push_back(3); q_adr.push_back(addr); q_dat.push_back(md[idx]);
      end
      if (hit) ms[idx] = 0;
    end

    @(negedge clk);
    chk(cpu_req_ready, req, "ready before request", cpu_req_ready, 1);
    cpu_req_valid = 1'b1; cpu_req_op = op[1:0];
    cpu_req_addr = addr[AW-1:0]; cpu_req_wdata = wd[DW-1:0];
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    got = 1'b0;
    c = 0;
    while (!got && c < 40) begin
      c++;
      if (cpu_resp_valid) begin
        got = 1'b1;
        if (op == 0) chk(int'(cpu_resp_rdata) == exp_rd, req, "read data",
                         int'(cpu_resp_rdata), exp_rd);
        chk(cpu_req_ready, "R11", "ready with response", cpu_req_ready, 1);
      end else if (bus_req_valid) begin
        if (q_cmd.size() == 0) begin
          chk(1'b0, req, "unexpected bus command", int'(bus_req_cmd), 9);
        end else begin
          int ec, ea, ed;
          ec = q_cmd.pop_front(); ea = q_adr.pop_front(); ed = q_dat.pop_front();
          chk(int'(bus_req_cmd) == ec, req, "bus command", int'(bus_req_cmd), ec);
          chk(int'(bus_req_addr) == ea, req, "bus address", int'(bus_req_addr), ea);
          if (ec == 3) chk(int'(bus_req_data) == ed, req, "write-back data",
                           int'(bus_req_data), ed);
        end
        bus_gnt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_gnt = 1'b0;
        if (bus_req_cmd <= 2'd1 && !cpu_req_ready && !cpu_resp_valid) begin
          bus_fill_valid = 1'b1; bus_fill_data = fd[DW-1:0]; bus_fill_shared = fsh;
          @(posedge clk);
          @(negedge clk);
          bus_fill_valid = 1'b0;
        end
      end else begin
        @(negedge clk);
      end
    end
    chk(got, req, "processor response seen", got, 1);
    chk(q_cmd.size() == 0, req, "missing bus commands", q_cmd.size(), 0);
  endtask

  task automatic do_snp(input int cmd, input int addr, input string req);
    int idx, tg, ev, ed, edat, ecp;
    bit hit, dirty;
    idx   = addr & 3;
    tg    = addr >> 2;
    hit   = (ms[idx] != 0) && (mt[idx] == tg);
    dirty = (ms[idx] == 3) || (ms[idx] == 4);
    ev = 0; ed = 0; edat = md[idx]; ecp = 0;
    if (hit) begin
      if (cmd == 0) begin
        ecp = 1;
        if (dirty) begin ev = 1; ed = 1; ms[idx] = 3; end
        else if (ms[idx] == 2) begin ev = 1; ms[idx] = 1; end
      end else if (cmd == 1) begin
        ev = (ms[idx] != 1); ed = dirty; ms[idx] = 0;
      end else if (cmd == 2) begin
        ms[idx] = 0;
      end
    end
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd[1:0]; snp_addr = addr[AW-1:0];
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    chk(int'(snp_resp_valid) == ev, req, "snoop answer valid", snp_resp_valid, ev);
    chk(int'(snp_copy) == ecp, req, "copies-exist", snp_copy, ecp);
    if (ev != 0) begin
      chk(int'(snp_resp_dirty) == ed, req, "snoop answer dirty", snp_resp_dirty, ed);
      chk(int'(snp_resp_data) == edat, req, "snoop answer data", int'(snp_resp_data), edat);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin ms[i] = 0; mt[i] = 0; md[i] = 0; end
    rst_n = 1'b0;
    cpu_req_valid = 1'b0; cpu_req_op = 2'd0; cpu_req_addr = '0; cpu_req_wdata = '0;
    bus_gnt = 1'b0; bus_fill_valid = 1'b0; bus_fill_data = '0; bus_fill_shared = 1'b0;
    snp_valid = 1'b0; snp_cmd = 2'd0; snp_addr = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    mon_on = 1'b1;
    // R1: reset state
    chk(cpu_req_ready, "R1", "ready after reset", cpu_req_ready, 1);
    chk(!bus_req_valid, "R1", "no bus request after reset", bus_req_valid, 0);
    chk(!cpu_resp_valid, "R1", "no response after reset", cpu_resp_valid, 0);
    chk(!snp_resp_valid, "R1", "no snoop answer after reset", snp_resp_valid, 0);
    do_snp(0, 'h10, "R1");

    // R2: read miss to exclusive, then hit
    do_cpu(0, 'h10, 0, 'h1111, 1'b0, "R2");
    do_cpu(0, 'h10, 0, 'h0bad, 1'b0, "R2");
    // R7: exclusive answers clean, then shared stays silent
    do_snp(0, 'h10, "R7");
    do_snp(0, 'h10, "R7");
    // R3: upgrade from shared
    do_cpu(1, 'h10, 'h2222, 0, 1'b0, "R3");
    // R6: modified to owned, owned stays owned
    do_snp(0, 'h10, "R6");
    do_snp(0, 'h10, "R6");
    // R5: write miss over owned victim, then R3 read-exclusive
    do_cpu(1, 'h24, 'h3333, 'h0f0f, 1'b0, "R5");
    // R4: evict modified
    do_cpu(2, 'h24, 0, 0, 1'b0, "R4");
    do_cpu(0, 'h24, 0, 'h4444, 1'b1, "R2");
    // R9: upgrade snoop on shared
    do_snp(2, 'h24, "R9");
    do_cpu(0, 'h24, 0, 'h5555, 1'b0, "R9");
    // R3: silent exclusive to modified
    do_cpu(1, 'h24, 'h6666, 0, 1'b0, "R3");
    // R8: read-exclusive snoop on modified, exclusive, shared
    do_snp(1, 'h24, "R8");
    do_cpu(0, 'h11, 0, 'h7777, 1'b0, "R8");
    do_snp(1, 'h11, "R8");
    do_cpu(0, 'h11, 0, 'h8888, 1'b1, "R8");
    do_snp(1, 'h11, "R8");
    do_cpu(0, 'h11, 0, 'h8989, 1'b1, "R8");
    // R5: clean victim dropped
    do_cpu(0, 'h10, 0, 'h9999, 1'b1, "R5");
    do_cpu(0, 'h24, 0, 'haaaa, 1'b0, "R5");
    // R4: evict exclusive and absent lines
    do_cpu(2, 'h24, 0, 0, 1'b0, "R4");
    do_cpu(2, 'h35, 0, 0, 1'b0, "R4");
    do_cpu(0, 'h24, 0, 'hbbbb, 1'b0, "R2");
    // R10: tag miss and write-back snoops ignored; line still exclusive
    do_snp(0, 'h10, "R10");
    do_snp(3, 'h24, "R10");
    do_snp(1, 'h34, "R10");
    do_cpu(1, 'h24, 'hcccc, 0, 1'b0, "R10");
    // R9 on owned, then owned eviction (R4)
    do_snp(0, 'h24, "R6");
    do_snp(2, 'h24, "R9");
    do_cpu(1, 'h24, 'hdddd, 'h0e0e, 1'b0, "R3");
    do_snp(0, 'h24, "R6");
    do_cpu(2, 'h24, 0, 0, 1'b0, "R4");
    // R5: read miss over modified victim
    do_cpu(1, 'h12, 'h1234, 'h0101, 1'b0, "R3");
    do_cpu(0, 'h26, 0, 'h5678, 1'b0, "R5");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule